// File: doc/BRIEF.md
# Clock-Output Enable Register Slave

This block is a two-wire serial slave that holds the control bytes of a clock fan-out buffer. A host on the SMBus turns each of twelve differential output pairs on or off. It also switches two feedback outputs and picks a 2-bit input threshold level. SCL and SDA are sampled and synchronised in the local system clock domain. SDA is driven open-drain through an output-enable: while `sda_oe` is high, the pad pulls the line low.

The slave answers one of two 7-bit addresses, chosen by a strap pin. The first data byte of every transfer is a command code with three parts:
- Bit 7 chooses single indexed access (1) or sequential block access (0).
- Bits 6:5 must match the level of a second strap pin, so two devices can share one address.
- Bits 4:0 give the byte index for single access.

A block transfer always starts at index 0. A block read begins with a byte count. Reads use a repeated start after the command code. Only indexes 22 and 23 hold storage. Every other index reads 0 and drops writes.

Top module: `clkbuf_smbus_ctl`

## Requirements
- R1: The slave acknowledges address 7'b1101001 when `addr_pick` is 1 and 7'b1101110 when it is 0. Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R2: Command bits 6:5 must be 2'b01 while `bus_id_sel` is 0 and 2'b10 while it is 1. A mismatch gets no acknowledge, and later bytes up to the next start have no effect.
- R3: Single write: the command has bit 7 = 1 and bits 4:0 = index. The next byte from the master is acknowledged and stored at that index.
- R4: Single read: after the command, a repeated start and the address with R/W = 1, the slave returns the byte at the command's index.
- R5: Block write: the command has bit 7 = 0. A count byte comes next, then data stored at index 0, 1, 2 and so on upward. A stop after any whole byte leaves later indexes untouched.
- R6: Block read: the slave first returns the count 24, then indexes 0, 1, 2 and so on. After the master gives no acknowledge, the slave leaves SDA released.
- R7: Indexes other than 22 and 23 read as 0x00, and writes to them have no effect.
- R8: After reset, index 22 is 0x0F and index 23 is 0xFF. So every pair is enabled, both feedback disables are 0 and `thresh` is 2'b00.
- R9: Index 22 bits 7:6 drive `thresh`, bit 5 drives `fb_a_dis` and bit 4 drives `fb_b_dis`. Index 22 bits 3:0 drive `pair_en[11:8]` (B5..B2). Index 23 bits 7:0 drive `pair_en[7:0]` (B1, B0, A5..A0).
- R10: `sda_oe` is only raised while SCL is low. A start condition at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_pick | input | 1 | Strap that selects the slave address |
| bus_id_sel | input | 1 | Strap that selects the expected command bits 6:5 |
| pair_en | output | 12 | Enable per output pair: [5:0] A0..A5, [11:6] B0..B5 |
| fb_a_dis | output | 1 | Disables feedback output A when 1 |
| fb_b_dis | output | 1 | Disables feedback output B when 1 |
| thresh | output | 2 | Input threshold select, 00 = nominal |

## Verification
Both bus inputs pass through a two-flop synchroniser, so every action of the slave lands two to three system clocks after the SCL edge that triggers it. An acknowledge or transmit bit appears that long after SCL falls. A register update appears that long after the falling edge that closes the eighth data bit. The bench master holds each SCL phase for eight system clocks and samples SDA in the middle of the high phase. It checks the output pins only after the stop condition, so each result is due well before it is read.

// File: rtl/clkbuf_smbus_ctl.sv
module clkbuf_smbus_ctl #(
  parameter logic [6:0] ADDR_HI   = 7'b1101001,
  parameter logic [6:0] ADDR_LO   = 7'b1101110,
  parameter int         REG_COUNT = 24,
  parameter int         THR_IDX   = 22,
  parameter int         EN_IDX    = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        addr_pick,
  input  logic        bus_id_sel,
  output logic [11:0] pair_en,
  output logic        fb_a_dis,
  output logic        fb_b_dis,
  output logic [1:0]  thresh
);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_CMD = 3'd2, ST_CNT = 3'd3,
    ST_WR = 3'd4, ST_TX = 3'd5, ST_IGN = 3'd6
  } st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic [4:0] ptr;
  logic       blk, cmd_ok, send_cnt, m_nack;
  logic [7:0] r_thr, r_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise  = scl_q[1] & ~scl_q[2];
  wire scl_fall  = ~scl_q[1] & scl_q[2];
  wire start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire sda_bit   = sda_q[1];

  wire [6:0] my_addr = addr_pick ? ADDR_HI : ADDR_LO;
  wire [1:0] id_want = bus_id_sel ? 2'b10 : 2'b01;
  wire       receiving = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_CNT) || (st == ST_WR);
  wire [7:0] rd_byte = (ptr == 5'(THR_IDX)) ? r_thr :
                       (ptr == 5'(EN_IDX))  ? r_en  : 8'h00;
  wire [7:0] tx_byte = send_cnt ? 8'(REG_COUNT) : rd_byte;
  wire [4:0] ptr_inc = ptr + {4'd0, ptr != 5'd31};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitn     <= 4'd0;
      sh       <= 8'h00;
      ptr      <= 5'd0;
      blk      <= 1'b0;
      cmd_ok   <= 1'b0;
      send_cnt <= 1'b0;
      m_nack   <= 1'b0;
      sda_oe   <= 1'b0;
      r_thr    <= 8'h0F;
      r_en     <= 8'hFF;
    end else if (start_det) begin
      st     <= ST_ADDR;
      bitn   <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      bitn   <= 4'd0;
      sda_oe <= 1'b0;
      cmd_ok <= 1'b0;
    end else if (st == ST_IDLE || st == ST_IGN) begin
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (bitn < 4'd8) begin
        if (receiving) sh <= {sh[6:0], sda_bit};
        bitn <= bitn + 4'd1;
      end else if (bitn == 4'd9 && st == ST_TX) begin
        m_nack <= sda_bit;
      end
    end else if (scl_fall) begin
      if (bitn >= 4'd1 && bitn <= 4'd7) begin
        if (st == ST_TX) begin
          sda_oe <= ~sh[7];
          sh     <= {sh[6:0], 1'b0};
        end
      end else if (bitn == 4'd8) begin
        bitn <= 4'd9;
        case (st)
          ST_ADDR:
            if (sh[7:1] == my_addr && (!sh[0] || cmd_ok)) begin
              sda_oe <= 1'b1;
              if (sh[0]) begin
                st       <= ST_TX;
                send_cnt <= blk;
              end else begin
                st     <= ST_CMD;
                cmd_ok <= 1'b0;
              end
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_IGN;
            end
          ST_CMD:
            if (sh[6:5] == id_want) begin
              sda_oe <= 1'b1;
              blk    <= ~sh[7];
              ptr    <= sh[7] ? sh[4:0] : 5'd0;
              cmd_ok <= 1'b1;
              st     <= sh[7] ? ST_WR : ST_CNT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_IGN;
            end
          ST_CNT: begin
            sda_oe <= 1'b1;
            st     <= ST_WR;
          end
          ST_WR: begin
            sda_oe <= 1'b1;
            if (ptr == 5'(THR_IDX)) r_thr <= sh;
            if (ptr == 5'(EN_IDX))  r_en  <= sh;
            ptr <= ptr_inc;
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (bitn == 4'd9) begin
        bitn <= 4'd0;
        if (st == ST_TX) begin
          if (!m_nack) begin
            sda_oe <= ~tx_byte[7];
            sh     <= {tx_byte[6:0], 1'b0};
            if (send_cnt) send_cnt <= 1'b0;
            else          ptr      <= ptr_inc;
          end else begin
            sda_oe <= 1'b0;
            st     <= ST_IGN;
          end
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end

  assign pair_en  = {r_thr[3:0], r_en};
  assign fb_a_dis = r_thr[5];
  assign fb_b_dis = r_thr[4];
  assign thresh   = r_thr[7:6];

endmodule

module clkbuf_smbus_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [11:0] pair_en,
  input logic        fb_a_dis,
  input logic        fb_b_dis,
  input logic [1:0]  thresh,
  input logic [2:0]  st,
  input logic [3:0]  bitn,
  input logic        start_det
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_ADDR = 3'd1;
  localparam logic [2:0] C_IGN  = 3'd6;

  assert_reset_values_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> (pair_en == 12'hFFF && !fb_a_dis && !fb_b_dis && thresh == 2'b00));

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == C_ADDR && bitn == 4'd0));

  assert_update_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pair_en, fb_a_dis, fb_b_dis, thresh}) |-> (sda_oe && !scl_i));

  assert_quiet_when_ignoring_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IGN || st == C_IDLE) |-> !sda_oe);
endmodule

bind clkbuf_smbus_ctl clkbuf_smbus_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .pair_en(pair_en), .fb_a_dis(fb_a_dis), .fb_b_dis(fb_b_dis), .thresh(thresh),
  .st(st), .bitn(bitn), .start_det(start_det)
);

// File: tb/clkbuf_smbus_ctl_tb.sv
module clkbuf_smbus_ctl_tb;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_pick = 1'b1;
  logic bus_id_sel = 1'b0;
  logic sda_oe;
  logic [11:0] pair_en;
  logic fb_a_dis, fb_b_dis;
  logic [1:0] thresh;
  wire sda_bus = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  logic [7:0] e22 = 8'h0F;
  logic [7:0] e23 = 8'hFF;
  logic [7:0] wbuf [24];
  logic [7:0] rbuf [24];

  always #(CLK_NS/2) clk = ~clk;

  clkbuf_smbus_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pick(addr_pick), .bus_id_sel(bus_id_sel), .pair_en(pair_en),
    .fb_a_dis(fb_a_dis), .fb_b_dis(fb_b_dis), .thresh(thresh)
  );

  function automatic logic [15:0] pins_exp(input logic [7:0] b22, input logic [7:0] b23);
    return {b22[3:0], b23, b22[5], b22[4], b22[7:6]};
  endfunction

  function automatic logic [6:0] addr7(input logic pick);
    return pick ? 7'b1101001 : 7'b1101110;
  endfunction

  function automatic logic [1:0] idf(input logic cs);
    return cs ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req);
    chk(req, {16'd0, pair_en, fb_a_dis, fb_b_dis, thresh}, {16'd0, pins_exp(e22, e23)});
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; w(HALF); scl_m = 1'b1; w(HALF);
    sda_m = 1'b0; w(HALF); scl_m = 1'b0; w(HALF);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; w(HALF); scl_m = 1'b1; w(HALF); sda_m = 1'b1; w(HALF);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; w(HALF); scl_m = 1'b1; w(HALF/2);
    r = sda_bus; w(HALF/2); scl_m = 1'b0; w(3);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic ack, output logic [7:0] d);
    logic r;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_bit(1'b1, r);
      d = {d[6:0], r};
    end
    m_bit(~ack, r);
  endtask

  task automatic byte_write(input logic pick, input logic cs, input logic [4:0] off,
                            input logic [7:0] data, output logic ok);
    logic a1, a2, a3;
    m_start;
    m_wbyte({addr7(pick), 1'b0}, a1);
    m_wbyte({1'b1, idf(cs), off}, a2);
    m_wbyte(data, a3);
    m_stop;
    ok = a1 & a2 & a3;
  endtask

  task automatic byte_read(input logic pick, input logic cs, input logic [4:0] off,
                           output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    m_start;
    m_wbyte({addr7(pick), 1'b0}, a1);
    m_wbyte({1'b1, idf(cs), off}, a2);
    m_start;
    m_wbyte({addr7(pick), 1'b1}, a3);
    m_rbyte(1'b0, d);
    m_stop;
    ok = a1 & a2 & a3;
  endtask

  task automatic block_write(input logic pick, input logic cs, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    m_start;
    m_wbyte({addr7(pick), 1'b0}, a); ok &= a;
    m_wbyte({1'b0, idf(cs), 5'd0}, a); ok &= a;
    m_wbyte(8'(n), a); ok &= a;
    for (int i = 0; i < n; i++) begin
      m_wbyte(wbuf[i], a); ok &= a;
    end
    m_stop;
  endtask

  task automatic block_read(input logic pick, input logic cs, input int n,
                            output logic [7:0] cnt, output logic released);
    logic a;
    m_start;
    m_wbyte({addr7(pick), 1'b0}, a);
    m_wbyte({1'b0, idf(cs), 5'd0}, a);
    m_start;
    m_wbyte({addr7(pick), 1'b1}, a);
    m_rbyte(1'b1, cnt);
    for (int i = 0; i < n; i++) m_rbyte(i != n - 1, rbuf[i]);
    w(HALF);
    released = sda_bus;
    m_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ok, rel, a;
    logic [7:0] d, cnt;
    logic [7:0] zor;
    void'($urandom(32'd4242));
    w(5);
    rst_n = 1'b1;
    w(5);

    chk_pins("R8 reset pins");

    block_read(1'b1, 1'b0, 24, cnt, rel);
    chk("R6 block count", {24'd0, cnt}, 32'd24);
    chk("R6 released after nack", {31'd0, rel}, 32'd1);
    zor = 8'h00;
    for (int i = 0; i < 22; i++) zor |= rbuf[i];
    chk("R7 unimplemented zero", {24'd0, zor}, 32'd0);
    chk("R8 byte22 reset", {24'd0, rbuf[22]}, 32'h0F);
    chk("R8 byte23 reset", {24'd0, rbuf[23]}, 32'hFF);

    byte_write(1'b1, 1'b0, 5'd23, 8'h5A, ok);
    e23 = 8'h5A;
    chk("R3 byte write ack", {31'd0, ok}, 32'd1);
    chk_pins("R9 byte23 map");

    byte_read(1'b1, 1'b0, 5'd23, d, ok);
    chk("R4 byte read", {23'd0, ok, d}, {23'd0, 1'b1, 8'h5A});

    addr_pick = 1'b0;
    m_start;
    m_wbyte({addr7(1'b1), 1'b0}, a);
    chk("R1 foreign address nack", {31'd0, a}, 32'd0);
    m_wbyte({1'b1, idf(1'b0), 5'd23}, a);
    m_wbyte(8'h00, a);
    m_stop;
    chk_pins("R1 foreign address no effect");

    byte_write(1'b0, 1'b0, 5'd22, 8'hB6, ok);
    e22 = 8'hB6;
    chk("R1 low address ack", {31'd0, ok}, 32'd1);
    chk_pins("R9 byte22 map");

    bus_id_sel = 1'b1;
    m_start;
    m_wbyte({addr7(1'b0), 1'b0}, a);
    m_wbyte({1'b1, 2'b01, 5'd22}, a);
    chk("R2 id mismatch nack", {31'd0, a}, 32'd0);
    m_wbyte(8'h00, a);
    chk("R2 ignored after nack", {31'd0, a}, 32'd0);
    m_stop;
    chk_pins("R2 mismatch no effect");

    byte_write(1'b0, 1'b1, 5'd5, 8'hFF, ok);
    byte_read(1'b0, 1'b1, 5'd5, d, ok);
    chk("R7 unimplemented write dropped", {23'd0, ok, d}, {23'd0, 1'b1, 8'h00});
    chk_pins("R7 pins unchanged");

    for (int i = 0; i < 24; i++) wbuf[i] = 8'($urandom);
    block_write(1'b0, 1'b1, 24, ok);
    e22 = wbuf[22];
    e23 = wbuf[23];
    chk("R5 block write ack", {31'd0, ok}, 32'd1);
    chk_pins("R5 block write pins");
    block_read(1'b0, 1'b1, 24, cnt, rel);
    chk("R5 block readback 22", {24'd0, rbuf[22]}, {24'd0, e22});
    chk("R5 block readback 23", {24'd0, rbuf[23]}, {24'd0, e23});
    zor = 8'h00;
    for (int i = 0; i < 22; i++) zor |= rbuf[i];
    chk("R7 block dropped", {24'd0, zor}, 32'd0);

    for (int i = 0; i < 3; i++) wbuf[i] = 8'hA5;
    block_write(1'b0, 1'b1, 3, ok);
    chk_pins("R5 short block no effect");

    block_read(1'b0, 1'b1, 3, cnt, rel);
    chk("R6 early nack release", {31'd0, rel}, 32'd1);
    chk("R6 count partial", {24'd0, cnt}, 32'd24);

    m_start;
    m_wbyte({addr7(1'b0), 1'b0}, a);
    byte_read(1'b0, 1'b1, 5'd22, d, ok);
    chk("R10 restart mid transfer", {23'd0, ok, d}, {23'd0, 1'b1, e22});

    for (int i = 0; i < 16; i++) begin
      logic pk, cs;
      logic [4:0] off;
      logic [7:0] dat;
      pk = 1'($urandom);
      cs = 1'($urandom);
      off = ($urandom % 2 == 0) ? 5'd22 : 5'd23;
      dat = 8'($urandom);
      addr_pick = pk;
      bus_id_sel = cs;
      byte_write(pk, cs, off, dat, ok);
      if (off == 5'd22) e22 = dat; else e23 = dat;
      chk_pins("R9 random write");
      byte_read(pk, cs, off, d, ok);
      chk("R4 random read", {23'd0, ok, d}, {23'd0, 1'b1, dat});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule